// File: doc/BRIEF.md
# Dual-Slope Center-Aligned PWM Generator

This block holds a 16-bit counter that climbs from zero to a ceiling value and then falls back to zero, over and over, advancing one step for each cycle in which the count-enable input is high. Two compare channels watch the counter. Each channel drives a waveform that flips only at the moment the counter arrives at that channel's compare value. The direction of the flip depends on which way the counter is moving, so the pulses sit symmetrically around the ceiling of each period.

The ceiling can be one of three fixed all-ones values (8, 9 or 10 bits wide) or a value held in a writable ceiling register. Compare values are written into shadow registers and only go live when the counter reaches the ceiling, so a new duty cycle never cuts a period short. Each channel has its own polarity input that inverts its waveform. A one-cycle overflow pulse marks each arrival at zero.

A slower up/down prescaled tick, interrupt logic and any bus protocol belong to the surroundings. This block only sees a count enable, a simple write strobe and the mode inputs.

Top module: `pwm_dual_slope`

## Requirements
- R1: After reset the count is 0 and counting upward. Each cycle with `tick` high moves the count by one: upward until it arrives at the ceiling, then downward until it arrives at 0. Direction reverses on the arrival tick, so no endpoint value is held for two ticks. With `tick` low the count and direction stay unchanged.
- R2: For a channel with polarity 0, the arrival of the count at the channel's live compare value drives the output low if the direction after that tick is upward, and high if it is downward. The output changes at no other time.
- R3: A channel with `polInv` bit set presents the complement of the level it would have with the bit clear.
- R4: `topSel` picks the ceiling: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF and 3 gives the ceiling register.
- R5: A write with `wrAddr` = 2 loads the ceiling register, and any value below 3 is stored as 3. The ceiling register resets to 0x00FF.
- R6: A write with `wrAddr` = 0 (channel 0) or 1 (channel 1) loads that channel's shadow compare. The shadow value becomes live on the tick that brings the count to the ceiling, and it already applies to the compare made on that tick. A shadow write in that same cycle is held for the next ceiling arrival.
- R7: `ovf` is high for exactly the one cycle after a tick that brings the count to 0.
- R8: With polarity 0, a live compare value of 0 keeps the output constantly low. A live compare value equal to the ceiling keeps it constantly high.
- R9: If the count is at or above the ceiling while counting upward, for example because the ceiling was lowered, the next tick steps the count down by one and turns the direction downward.
- R10: After reset the shadow and live compares are 0, both raw channel levels are low and `ovf` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable; one counter step per high cycle |
| topSel | input | 2 | Ceiling source select |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write target: 0/1 channel shadow compare, 2 ceiling register |
| wrData | input | 16 | Write data |
| polInv | input | 2 | Per-channel output inversion |
| pwmOut | output | 2 | Channel waveforms |
| cnt | output | 16 | Current count |
| dirUp | output | 1 | Current direction, 1 = upward |
| ovf | output | 1 | One-cycle pulse after arrival at zero |

## Verification
Two things can land on the same clock edge: a shadow-compare write and the ceiling-arrival tick that copies the shadow into the live compare. Other coincidences can also land together: a ceiling-register write while the count is already above the new ceiling, and a compare match on the very tick where the live value changes. The bench aims directed writes at the cycle just before the ceiling is reached, and it lowers the ceiling in the middle of an upward ramp. Randomized writes fall on arbitrary ticks. A bench model steps in lockstep with the design and judges every cycle. It applies the rule that the live copy takes the old shadow contents while the new write waits for the next period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Strobes passed from the counter control to the compare datapath.
  typedef struct packed {
    logic adv;      // counter steps this cycle
    logic hitTop;   // the step arrives at the ceiling
    logic hitZero;  // the step arrives at zero
    logic dirNext;  // direction after this step, 1 = upward
  } pwmStrobe_t;

  localparam int unsigned MIN_TOP_VAL = 3;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BASE_BITS = 8,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [SEL_W-1:0] topSel,
  input  logic [CNT_W-1:0] topReg,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cntNext,
  output logic [CNT_W-1:0] curTop,
  output logic             dirUp,
  output logic             ovf,
  output pwmStrobe_t       strobe
);

  localparam logic [SEL_W-1:0] SEL_REG = {SEL_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic dirNext;

  // Ceiling selection: fixed all-ones widths or the ceiling register.
  always_comb begin
    if (topSel == SEL_REG) begin
      curTop = topReg;
    end else begin
      curTop = (ONE << (BASE_BITS + 32'(topSel))) - ONE;
    end
  end

  // Next count and direction.
  always_comb begin
    cntNext = cnt;
    dirNext = dirUp;
    if (tick) begin
      if (dirUp) begin
        if (cnt >= curTop) begin
          cntNext = cnt - ONE;
          dirNext = 1'b0;
        end else begin
          cntNext = cnt + ONE;
          if (cnt + ONE == curTop) begin
            dirNext = 1'b0;
          end
        end
      end else begin
        cntNext = cnt - ONE;
        if (cnt == ONE) begin
          dirNext = 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.adv     = tick;
    strobe.hitTop  = tick && (cntNext == curTop);
    strobe.hitZero = tick && (cntNext == '0);
    strobe.dirNext = dirNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      dirUp <= 1'b1;
      ovf   <= 1'b0;
    end else begin
      cnt   <= cntNext;
      dirUp <= dirNext;
      ovf   <= strobe.hitZero;
    end
  end

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 2,
  parameter int unsigned ADDR_W = 2,
  parameter logic [CNT_W-1:0] TOP_RST = CNT_W'(255)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [N_CH-1:0]   polInv,
  input  logic [CNT_W-1:0]  cntNext,
  input  pwmStrobe_t        strobe,
  output logic [CNT_W-1:0]  topReg,
  output logic [N_CH-1:0]   outRaw,
  output logic [N_CH-1:0]   pwmOut
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(N_CH);
  localparam logic [CNT_W-1:0]  MIN_TOP  = CNT_W'(MIN_TOP_VAL);

  // Ceiling register, clamped to the minimum on write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topReg <= TOP_RST;
    end else if (wrEn && (wrAddr == TOP_ADDR)) begin
      topReg <= (wrData < MIN_TOP) ? MIN_TOP : wrData;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : gCh
    logic [CNT_W-1:0] cmpBuf;
    logic [CNT_W-1:0] cmpAct;
    logic [CNT_W-1:0] cmpEff;
    logic             match;

    // The value that goes live on this tick already governs its compare.
    assign cmpEff = strobe.hitTop ? cmpBuf : cmpAct;
    assign match  = strobe.adv && (cntNext == cmpEff);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpBuf <= '0;
      end else if (wrEn && (wrAddr == ADDR_W'(g))) begin
        cmpBuf <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpAct <= '0;
      end else if (strobe.hitTop) begin
        cmpAct <= cmpBuf;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outRaw[g] <= 1'b0;
      end else if (match) begin
        outRaw[g] <= !strobe.dirNext;
      end
    end

    assign pwmOut[g] = outRaw[g] ^ polInv[g];
  end

endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned N_CH      = 2,
  parameter int unsigned BASE_BITS = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned ADDR_W    = $clog2(N_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [SEL_W-1:0]  topSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [N_CH-1:0]   polInv,
  output logic [N_CH-1:0]   pwmOut,
  output logic [CNT_W-1:0]  cnt,
  output logic              dirUp,
  output logic              ovf
);

  localparam logic [CNT_W-1:0] TOP_RST = (CNT_W'(1) << BASE_BITS) - CNT_W'(1);

  pwmStrobe_t       strobe;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] curTop;
  logic [CNT_W-1:0] topReg;
  logic [N_CH-1:0]  outRaw;

  pwm_ctrl #(
    .CNT_W    (CNT_W),
    .BASE_BITS(BASE_BITS),
    .SEL_W    (SEL_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .topSel (topSel),
    .topReg (topReg),
    .cnt    (cnt),
    .cntNext(cntNext),
    .curTop (curTop),
    .dirUp  (dirUp),
    .ovf    (ovf),
    .strobe (strobe)
  );

  pwm_datapath #(
    .CNT_W  (CNT_W),
    .N_CH   (N_CH),
    .ADDR_W (ADDR_W),
    .TOP_RST(TOP_RST)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .polInv (polInv),
    .cntNext(cntNext),
    .strobe (strobe),
    .topReg (topReg),
    .outRaw (outRaw),
    .pwmOut (pwmOut)
  );

endmodule

// File: rtl/pwm_dual_slope_chk.sv
module pwm_dual_slope_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             dirUp,
  input logic             ovf,
  input logic [N_CH-1:0]  outRaw,
  input logic [CNT_W-1:0] curTop
);

  // R1: no tick, no movement
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(cnt) && $stable(dirUp)));

  // R1: a downward tick above one decrements and keeps the direction
  p_down_r1: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !dirUp && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1) && !dirUp));

  // R2: raw levels move only on ticks
  p_raw_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(outRaw));

  // R5: ceiling never below the minimum
  p_top_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    curTop >= CNT_W'(3));

  // R7: overflow pulse only at zero, upward, and never two in a row
  p_ovf_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (cnt == '0 && dirUp));

  p_ovf_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> !ovf);

endmodule

bind pwm_dual_slope pwm_dual_slope_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .tick  (tick),
  .cnt   (cnt),
  .dirUp (dirUp),
  .ovf   (ovf),
  .outRaw(outRaw),
  .curTop(curTop)
);

// File: tb/sim_pwm_dual_slope.sv
`timescale 1ns/1ps
module sim_pwm_dual_slope;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        drvTick = 1'b0;
  logic [1:0]  drvSel = 2'd0;
  logic        drvWr = 1'b0;
  logic [1:0]  drvAddr = 2'd0;
  logic [15:0] drvData = 16'd0;
  logic [1:0]  drvPol = 2'd0;
  logic [1:0]  pwmOut;
  logic [15:0] cnt;
  logic        dirUp;
  logic        ovf;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  bit reported = 1'b0;
  int unsigned peak = 0;

  // reference model state
  logic [15:0] mCnt = 16'd0;
  logic        mUp = 1'b1;
  logic        mOvf = 1'b0;
  logic [15:0] mTopReg = 16'h00FF;
  logic [15:0] mBuf [2] = '{16'd0, 16'd0};
  logic [15:0] mAct [2] = '{16'd0, 16'd0};
  logic [1:0]  mRaw = 2'b00;

  always #4 clk = ~clk;

  pwm_dual_slope u0 (
    .clk(clk), .rstN(rstN), .tick(drvTick), .topSel(drvSel),
    .wrEn(drvWr), .wrAddr(drvAddr), .wrData(drvData), .polInv(drvPol),
    .pwmOut(pwmOut), .cnt(cnt), .dirUp(dirUp), .ovf(ovf)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    end
  endtask

  function automatic logic [15:0] modelTop();
    if (drvSel == 2'd3) return mTopReg;
    return (16'd1 << (8 + 32'(drvSel))) - 16'd1;
  endfunction

  // One clock: step the model with the driven inputs, then compare after the edge.
  task automatic cycle(string tag);
    logic [15:0] top;
    logic [15:0] nx;
    logic        nd;
    logic        hTop;
    top = modelTop();
    nx = mCnt;
    nd = mUp;
    if (drvTick) begin
      if (mUp) begin
        if (mCnt >= top) begin nx = mCnt - 16'd1; nd = 1'b0; end
        else begin nx = mCnt + 16'd1; if (nx == top) nd = 1'b0; end
      end else begin
        nx = mCnt - 16'd1;
        if (nx == 16'd0) nd = 1'b1;
      end
    end
    hTop = drvTick && (nx == top);
    for (int ch = 0; ch < 2; ch++) begin
      logic [15:0] eff;
      eff = hTop ? mBuf[ch] : mAct[ch];
      if (drvTick && nx == eff) mRaw[ch] = !nd;
      if (hTop) mAct[ch] = mBuf[ch];
    end
    if (drvWr) begin
      if (drvAddr < 2'd2) mBuf[drvAddr] = drvData;
      else if (drvAddr == 2'd2) mTopReg = (drvData < 16'd3) ? 16'd3 : drvData;
    end
    mOvf = drvTick && (nx == 16'd0);
    mCnt = nx;
    mUp = nd;
    @(posedge clk);
    #1;
    check("R1", "cnt", 32'(cnt), 32'(mCnt));
    check("R1", "dirUp", 32'(dirUp), 32'(mUp));
    check("R7", "ovf", 32'(ovf), 32'(mOvf));
    check(tag, "pwmOut", 32'(pwmOut), 32'(mRaw ^ drvPol));
    if (32'(cnt) > peak) peak = 32'(cnt);
    @(negedge clk);
  endtask

  task automatic idleIn();
    drvWr = 1'b0;
    drvAddr = 2'd3;
  endtask

  task automatic writeReg(logic [1:0] a, logic [15:0] d, logic tk, string tag);
    drvWr = 1'b1; drvAddr = a; drvData = d; drvTick = tk;
    cycle(tag);
    idleIn();
  endtask

  task automatic run(int n, string tag);
    drvTick = 1'b1;
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idleIn();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10", "cnt", 32'(cnt), 32'd0);
    check("R10", "dirUp", 32'(dirUp), 32'd1);
    check("R10", "pwmOut", 32'(pwmOut), 32'd0);
    check("R10", "ovf", 32'(ovf), 32'd0);

    // R4: fixed ceilings
    for (int s = 0; s < 3; s++) begin
      logic [15:0] expTop;
      expTop = (16'd1 << (8 + s)) - 16'd1;
      drvSel = 2'(s);
      peak = 0;
      run(2 * 32'(expTop) + 4, "R4");
      check("R4", "peak", peak, 32'(expTop));
      while (!(mCnt == 16'd0)) cycle("R4");
    end

    // R5: ceiling register clamp
    drvSel = 2'd3;
    writeReg(2'd2, 16'd1, 1'b0, "R5");
    peak = 0;
    run(20, "R5");
    check("R5", "peak", peak, 32'd3);

    // R6: shadow write in the cycle of the ceiling arrival
    writeReg(2'd2, 16'd40, 1'b1, "R6");
    writeReg(2'd0, 16'd20, 1'b1, "R6");
    writeReg(2'd1, 16'd8, 1'b1, "R6");
    for (int i = 0; i < 200 && !(mUp && mCnt == 16'd39); i++) cycle("R6");
    writeReg(2'd0, 16'd5, 1'b1, "R6");
    run(200, "R6");

    // R8: compare at zero and at the ceiling
    writeReg(2'd0, 16'd0, 1'b1, "R8");
    writeReg(2'd1, 16'd40, 1'b1, "R8");
    run(170, "R8");
    for (int i = 0; i < 90; i++) begin
      cycle("R8");
      check("R8", "ch0 low", 32'(pwmOut[0]), 32'd0);
      check("R8", "ch1 high", 32'(pwmOut[1]), 32'd1);
    end

    // R3: inverted polarity
    writeReg(2'd0, 16'd12, 1'b1, "R3");
    writeReg(2'd1, 16'd30, 1'b1, "R3");
    drvPol = 2'b11;
    run(240, "R3");
    drvPol = 2'b01;
    run(100, "R3");

    // R9: ceiling lowered below the count while climbing
    drvPol = 2'b00;
    for (int i = 0; i < 200 && !(mUp && mCnt == 16'd30); i++) cycle("R9");
    writeReg(2'd2, 16'd10, 1'b1, "R9");
    drvTick = 1'b1;
    cycle("R9");
    check("R9", "cnt after reversal", 32'(cnt), 32'd30);
    check("R9", "dir after reversal", 32'(dirUp), 32'd0);
    run(80, "R9");

    // R2: randomized mix
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      drvTick = ($urandom_range(0, 3) != 0);
      if (r < 6) begin
        drvWr = 1'b1;
        drvAddr = 2'($urandom_range(0, 2));
        if (drvAddr == 2'd2) drvData = 16'($urandom_range(0, 60));
        else drvData = 16'($urandom_range(0, 64));
      end else if (r == 6) begin
        drvPol = 2'($urandom_range(0, 3));
      end else if (r == 7 && $urandom_range(0, 40) == 0) begin
        drvSel = 2'($urandom_range(0, 3));
      end else if (drvSel != 2'd3 && r == 8) begin
        drvSel = 2'd3;
      end
      cycle("R2");
      idleIn();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule